// File: doc/BRIEF.md
# SPD-Driven DRAM Configuration Sequencer

After reset, a DRAM controller has to be set up for whatever memory module is fitted. This block does that setup in hardware once it receives a start pulse. It first writes the four address-window size registers. Next it fetches the serial-presence-detect bytes it needs from the module, one byte at a time, over a request/acknowledge byte-read port. From those bytes it works out four things: whether the module is registered, the device width, the highest supported CAS latency and the device density.

It then programs the controller through a simple register-bus master. The registers it writes are the configuration word, the mode register, the control register with its burst-delay field, the address-control density code and, for DDR2 only, the extended mode register. Each mode-register update is wrapped in the same handshake with the operation register. First a NOP command is written and the operation register is polled until it reads zero. Then the new mode value is written, followed by the matching set command, and the operation register is polled to zero again. Every poll is bounded by a cycle budget.

The sequence ends with exactly one of two flags: done or error. Both flags stay set until the next start pulse. No register write is issued after either flag rises.

Top module: `spd_cfg_seq`

## Requirements
- R1: After reset, done and error are 0, and neither the byte-read request nor any bus access occurs until start is pulsed.
- R2: After start, the first four bus writes go to register indices 1, 2 and 3 with data 0, then to index 0. The index-0 data is ((req_size − 1) AND BASE_MASK) OR 1, using the req_size captured at start.
- R3: SPD bytes are requested at offsets 3 (row bits), 4 (column bits), 13 (device width), 17 (bank count) and 18 (CAS bitmap), in that order. A sixth request follows at offset 20 when ddr2=1 or offset 21 when ddr2=0. spd_req holds with a stable spd_addr until spd_ack.
- R4: The module counts as registered when ddr2=1 and (byte 20 AND 0x11) ≠ 0, or when ddr2=0 and bit 1 of byte 21 is set. The config word written to index 4 carries this flag in bit 17.
- R5: The config word is CFG_BASE OR (registered<<17) OR (ddr2<<19) OR a width code in bits [21:20]: 2'b10 when the width byte is 16, 2'b01 when it is 8. Any other width byte raises error right after the window writes, with no config write.
- R6: The CAS index is the bit position of the highest set bit of byte 18; an all-zero byte gives index 0. For DDR1, the mode value and burst delay are: index 1 gives 0x52 and 3, index 2 gives 0x22 and 3, index 3 gives 0x62 and 4, index 4 gives 0x32 and 4. Every other index gives 0x42 and 5.
- R7: For DDR2, index 3 gives 0x32 and delay 4, and indices 4 and 5 both give 0x42 and delay 5, with 0x400 ORed into the mode value. Any other index raises error after the config write and before any further write.
- R8: A mode update is the following sequence: write 5 to index 7 (operation), poll index 7 until it reads 0, write index 5 (mode), write 3 to index 7, then poll again until it reads 0. Bus reads go only to index 7.
- R9: Index 8 (control) is written with CTRL_BASE OR ((burst delay + registered) << DLY_LSB).
- R10: Density is ((1 << (rows+cols)) × width × banks) >> 20. A density of 0x80 writes 0x00 to index 9, 0x100 writes 0x10 and 0x200 writes 0x20. Any other density, or rows+cols ≥ 32, raises error with no write to index 9.
- R11: Only when ddr2=1, an extended-mode update follows the address-control write: write 5 to index 7, poll, write EMR_VALUE to index 6, write 4 to index 7, poll.
- R12: If a poll has not read 0 within POLL_LIMIT cycles, error rises and no further access is made.
- R13: Each run ends with exactly one of done or error set. No bus or SPD access occurs while either flag is set, and start clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| ddr2 | input | 1 | Memory type: 1 = DDR2, 0 = DDR1 |
| req_size | input | DW | Requested size for window 0 |
| spd_req | output | 1 | SPD byte request, held until acknowledged |
| spd_addr | output | 8 | SPD byte offset |
| spd_ack | input | 1 | One-cycle acknowledge with data |
| spd_data | input | 8 | SPD byte value |
| bus_wr | output | 1 | One-cycle register write strobe |
| bus_rd | output | 1 | One-cycle register read strobe |
| bus_addr | output | AW | Register index |
| bus_wdata | output | DW | Write data |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | DW | Read data |
| done | output | 1 | Run finished successfully (sticky) |
| error | output | 1 | Run aborted (sticky) |

## Verification
Every write strobe is registered, so it appears one cycle after the state that decides it. An abort flag appears in the cycle after the last write, and done appears one cycle after the final poll reads zero. The bench does not predict absolute cycle numbers. Instead it logs each bus write and each SPD request at the falling edge, compares the whole logged sequence against the list it computes from the requirements, and checks the flags only after one of them has risen. It then keeps sampling for eight more cycles to confirm that no late access appears. Read data is returned at the falling edge of the same cycle as the read strobe, so the sequencer sees it at the next rising edge. Poll busy lengths of 0 to 2 reads and a never-clearing operation register are all exercised.

// File: rtl/spdseq_pkg.sv
package spdseq_pkg;
  // register indices on the configuration bus
  typedef enum logic [3:0] {
    RG_WIN0 = 4'd0, RG_WIN1 = 4'd1, RG_WIN2 = 4'd2, RG_WIN3 = 4'd3,
    RG_CFG  = 4'd4, RG_MODE = 4'd5, RG_EMR  = 4'd6, RG_OP   = 4'd7,
    RG_CTRL = 4'd8, RG_ACTL = 4'd9
  } reg_id_e;

  // operation register command codes
  localparam logic [3:0] OPC_IDLE = 4'd0;
  localparam logic [3:0] OPC_MRS  = 4'd3;
  localparam logic [3:0] OPC_EMRS = 4'd4;
  localparam logic [3:0] OPC_NOP  = 4'd5;

  // config word field positions
  localparam int CFG_REG_BIT  = 17;
  localparam int CFG_TYPE_BIT = 19;
  localparam int CFG_WID_LSB  = 20;

  // number of SPD bytes fetched per run
  localparam int SPD_N = 6;

  function automatic logic [7:0] spd_offset(input logic [2:0] idx, input logic is_ddr2);
    case (idx)
      3'd0:    return 8'd3;
      3'd1:    return 8'd4;
      3'd2:    return 8'd13;
      3'd3:    return 8'd17;
      3'd4:    return 8'd18;
      default: return is_ddr2 ? 8'd20 : 8'd21;
    endcase
  endfunction
endpackage

// File: rtl/spd_decode.sv
module spd_decode
  import spdseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          ddr2,
  input  logic [7:0]    rows,
  input  logic [7:0]    cols,
  input  logic [7:0]    dev_w,
  input  logic [7:0]    banks,
  input  logic [7:0]    cas_map,
  input  logic [7:0]    mtype,
  output logic          registered,
  output logic          width_ok,
  output logic          x16,
  output logic          cas_ok,
  output logic [DW-1:0] mode_word,
  output logic [3:0]    burst_dly,
  output logic          dens_ok,
  output logic [7:0]    actl_code
);
  logic [2:0]  top;
  logic [7:0]  code;
  logic [8:0]  sum;
  logic [15:0] wb;
  logic [47:0] prod;
  logic [27:0] dens;

  always_comb begin
    registered = ddr2 ? (|(mtype & 8'h11)) : mtype[1];
    width_ok   = (dev_w == 8'd8) || (dev_w == 8'd16);
    x16        = (dev_w == 8'd16);

    top = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (cas_map[i]) top = 3'(i);
    end

    cas_ok    = 1'b1;
    code      = 8'h42;
    burst_dly = 4'd5;
    if (!ddr2) begin
      case (top)
        3'd1: begin code = 8'h52; burst_dly = 4'd3; end
        3'd2: begin code = 8'h22; burst_dly = 4'd3; end
        3'd3: begin code = 8'h62; burst_dly = 4'd4; end
        3'd4: begin code = 8'h32; burst_dly = 4'd4; end
        default: ;
      endcase
    end else begin
      case (top)
        3'd3:       begin code = 8'h32; burst_dly = 4'd4; end
        3'd4, 3'd5: begin code = 8'h42; burst_dly = 4'd5; end
        default:    cas_ok = 1'b0;
      endcase
    end
    mode_word = DW'(code) | (ddr2 ? DW'(12'h400) : '0);

    sum  = 9'(rows) + 9'(cols);
    wb   = 16'(dev_w) * 16'(banks);
    prod = (sum < 9'd32) ? (48'(wb) << sum[4:0]) : 48'd0;
    dens = prod[47:20];
    dens_ok   = 1'b1;
    actl_code = 8'h00;
    case (dens)
      28'h80:  actl_code = 8'h00;
      28'h100: actl_code = 8'h10;
      28'h200: actl_code = 8'h20;
      default: dens_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/op_poll_timer.sv
module op_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spd_cfg_seq.sv
module spd_cfg_seq
  import spdseq_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          AW         = 4,
  parameter int          POLL_LIMIT = 1024,
  parameter logic [31:0] BASE_MASK  = 32'hFFFF_0000,
  parameter logic [31:0] CFG_BASE   = 32'h0000_C000,
  parameter logic [31:0] CTRL_BASE  = 32'h0000_1000,
  parameter int          DLY_LSB    = 24,
  parameter logic [31:0] EMR_VALUE  = 32'h0000_0440
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ddr2,
  input  logic [DW-1:0] req_size,
  output logic          spd_req,
  output logic [7:0]    spd_addr,
  input  logic          spd_ack,
  input  logic [7:0]    spd_data,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_rvalid,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          error
);
  typedef enum logic [4:0] {
    S_IDLE, S_WIN, S_SPD, S_SPDW, S_CFG, S_CASCHK,
    S_MNOP, S_MWR, S_MCMD, S_CTRL, S_ACTL,
    S_ENOP, S_EWR, S_ECMD, S_PRD, S_PWT, S_FIN
  } st_e;

  st_e           st, ret;
  logic [1:0]    widx;
  logic [2:0]    sidx;
  logic          ddr2_q;
  logic [DW-1:0] size_q;
  logic [7:0]    spd_b [SPD_N];

  logic          registered, width_ok, x16, cas_ok, dens_ok, expired;
  logic [DW-1:0] mode_word;
  logic [3:0]    burst_dly;
  logic [7:0]    actl_code;
  logic [DW-1:0] win0_word, cfg_word, ctrl_word;

  spd_decode #(.DW(DW)) u_dec (
    .ddr2(ddr2_q), .rows(spd_b[0]), .cols(spd_b[1]), .dev_w(spd_b[2]),
    .banks(spd_b[3]), .cas_map(spd_b[4]), .mtype(spd_b[5]),
    .registered(registered), .width_ok(width_ok), .x16(x16), .cas_ok(cas_ok),
    .mode_word(mode_word), .burst_dly(burst_dly), .dens_ok(dens_ok),
    .actl_code(actl_code)
  );

  op_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst(rst), .run((st == S_PRD) || (st == S_PWT)), .expired(expired)
  );

  assign win0_word = ((size_q - 1'b1) & DW'(BASE_MASK)) | DW'(1);
  assign cfg_word  = DW'(CFG_BASE) | (DW'(registered) << CFG_REG_BIT)
                   | (DW'(ddr2_q) << CFG_TYPE_BIT)
                   | ((x16 ? DW'(2) : DW'(1)) << CFG_WID_LSB);
  assign ctrl_word = DW'(CTRL_BASE) | (DW'(burst_dly + 4'(registered)) << DLY_LSB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ret       <= S_IDLE;
      widx      <= '0;
      sidx      <= '0;
      ddr2_q    <= 1'b0;
      size_q    <= '0;
      spd_req   <= 1'b0;
      spd_addr  <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      for (int i = 0; i < SPD_N; i++) spd_b[i] <= '0;
    end else begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          done   <= 1'b0;
          error  <= 1'b0;
          ddr2_q <= ddr2;
          size_q <= req_size;
          widx   <= '0;
          st     <= S_WIN;
        end
        S_WIN: begin
          bus_wr    <= 1'b1;
          bus_addr  <= (widx == 2'd3) ? AW'(RG_WIN0) : AW'(widx + 2'd1);
          bus_wdata <= (widx == 2'd3) ? win0_word : '0;
          widx      <= widx + 2'd1;
          if (widx == 2'd3) begin
            sidx <= '0;
            st   <= S_SPD;
          end
        end
        S_SPD: begin
          spd_req  <= 1'b1;
          spd_addr <= spd_offset(sidx, ddr2_q);
          st       <= S_SPDW;
        end
        S_SPDW: if (spd_ack) begin
          spd_req     <= 1'b0;
          spd_b[sidx] <= spd_data;
          if (sidx == 3'(SPD_N - 1)) st <= S_CFG;
          else begin
            sidx <= sidx + 3'd1;
            st   <= S_SPD;
          end
        end
        S_CFG: begin
          if (!width_ok) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else begin
            bus_wr    <= 1'b1;
            bus_addr  <= AW'(RG_CFG);
            bus_wdata <= cfg_word;
            st        <= S_CASCHK;
          end
        end
        S_CASCHK: begin
          if (!cas_ok) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else st <= S_MNOP;
        end
        S_MNOP, S_ENOP: begin
          bus_wr    <= 1'b1;
          bus_addr  <= AW'(RG_OP);
          bus_wdata <= DW'(OPC_NOP);
          ret       <= (st == S_MNOP) ? S_MWR : S_EWR;
          st        <= S_PRD;
        end
        S_MWR: begin
          bus_wr    <= 1'b1;
          bus_addr  <= AW'(RG_MODE);
          bus_wdata <= mode_word;
          st        <= S_MCMD;
        end
        S_MCMD: begin
          bus_wr    <= 1'b1;
          bus_addr  <= AW'(RG_OP);
          bus_wdata <= DW'(OPC_MRS);
          ret       <= S_CTRL;
          st        <= S_PRD;
        end
        S_CTRL: begin
          bus_wr    <= 1'b1;
          bus_addr  <= AW'(RG_CTRL);
          bus_wdata <= ctrl_word;
          st        <= S_ACTL;
        end
        S_ACTL: begin
          if (!dens_ok) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else begin
            bus_wr    <= 1'b1;
            bus_addr  <= AW'(RG_ACTL);
            bus_wdata <= DW'(actl_code);
            st        <= ddr2_q ? S_ENOP : S_FIN;
          end
        end
        S_EWR: begin
          bus_wr    <= 1'b1;
          bus_addr  <= AW'(RG_EMR);
          bus_wdata <= DW'(EMR_VALUE);
          st        <= S_ECMD;
        end
        S_ECMD: begin
          bus_wr    <= 1'b1;
          bus_addr  <= AW'(RG_OP);
          bus_wdata <= DW'(OPC_EMRS);
          ret       <= S_FIN;
          st        <= S_PRD;
        end
        S_PRD: begin
          bus_rd   <= 1'b1;
          bus_addr <= AW'(RG_OP);
          st       <= S_PWT;
        end
        S_PWT: begin
          if (bus_rvalid && (bus_rdata == '0)) st <= ret;
          else if (expired) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else if (bus_rvalid) st <= S_PRD;
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spd_cfg_seq_chk.sv
module spd_cfg_seq_chk
  import spdseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          spd_req,
  input logic          spd_ack,
  input logic [7:0]    spd_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          done,
  input logic          error
);
  logic [DW-1:0] last_op;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op   <= '0;
      last_addr <= '1;
    end else if (bus_wr) begin
      last_addr <= bus_addr;
      if (bus_addr == AW'(RG_OP)) last_op <= bus_wdata;
    end
  end

  assert_flags_excl_R13: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  assert_quiet_after_end_R13: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> (!bus_wr && !bus_rd && !spd_req));
  assert_one_access_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_wr, bus_rd}));
  assert_poll_addr_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> (bus_addr == AW'(RG_OP)));
  assert_mode_after_nop_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(RG_MODE)) |-> (last_op == DW'(OPC_NOP)));
  assert_emr_after_nop_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(RG_EMR)) |-> (last_op == DW'(OPC_NOP)));
  assert_mrs_after_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(RG_OP) && bus_wdata == DW'(OPC_MRS))
      |-> (last_addr == AW'(RG_MODE)));
  assert_spd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (spd_req && !spd_ack) |=> (spd_req && $stable(spd_addr)));
endmodule

bind spd_cfg_seq spd_cfg_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .spd_req(spd_req), .spd_ack(spd_ack),
  .spd_addr(spd_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done), .error(error)
);

// File: tb/sim_spd_cfg_seq.sv
`timescale 1ns/1ps
module sim_spd_cfg_seq;
  localparam int          DW    = 32;
  localparam int          AW    = 4;
  localparam int          PL    = 40;
  localparam logic [31:0] MASK  = 32'hFFFF_0000;
  localparam logic [31:0] CFGB  = 32'h0000_C000;
  localparam logic [31:0] CTRLB = 32'h0000_1000;
  localparam int          DLSB  = 24;
  localparam logic [31:0] EMRV  = 32'h0000_0440;
  localparam int A_CFG = 4, A_MODE = 5, A_EMR = 6, A_OP = 7, A_CTRL = 8, A_ACTL = 9;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, ddr2 = 1'b0;
  logic [DW-1:0] req_size = 32'h1000_0000;
  logic spd_req, spd_ack = 1'b0;
  logic [7:0] spd_addr, spd_data = 8'h00;
  logic bus_wr, bus_rd, bus_rvalid = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic done, error;

  always #2 clk = ~clk;

  spd_cfg_seq #(.DW(DW), .AW(AW), .POLL_LIMIT(PL), .BASE_MASK(MASK),
    .CFG_BASE(CFGB), .CTRL_BASE(CTRLB), .DLY_LSB(DLSB), .EMR_VALUE(EMRV)) u0 (
    .clk(clk), .rst(rst), .start(start), .ddr2(ddr2), .req_size(req_size),
    .spd_req(spd_req), .spd_addr(spd_addr), .spd_ack(spd_ack), .spd_data(spd_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .done(done), .error(error));

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  // module image and responder settings
  logic [7:0] m_rows = 13, m_cols = 10, m_wid = 8, m_banks = 4, m_cas = 8'h1C;
  logic [7:0] m_b20 = 0, m_b21 = 0;
  int pend = 0;
  bit stuck = 0;

  // observed traffic
  logic [AW-1:0] log_a [32];
  logic [31:0]   log_d [32];
  int log_n = 0;
  logic [7:0] spd_log [8];
  int spd_n = 0;
  logic [31:0] op_val = 0;
  int op_left = 0;
  int sp_cnt = 0;

  // expected traffic
  logic [AW-1:0] ea [32];
  logic [31:0]   ed [32];
  int en;
  bit exp_err;
  logic [7:0] es [8];
  int esn;

  function automatic logic [7:0] spd_byte(input logic [7:0] off);
    case (off)
      8'd3: return m_rows;
      8'd4: return m_cols;
      8'd13: return m_wid;
      8'd17: return m_banks;
      8'd18: return m_cas;
      8'd20: return m_b20;
      8'd21: return m_b21;
      default: return 8'hEE;
    endcase
  endfunction

  // register bus model and write logger
  always @(negedge clk) begin
    bus_rvalid <= 1'b0;
    if (!rst) begin
      if (bus_wr) begin
        if (log_n < 32) begin
          log_a[log_n] = bus_addr;
          log_d[log_n] = bus_wdata;
        end
        log_n++;
        if (bus_addr == AW'(A_OP)) begin
          op_val = bus_wdata;
          op_left = pend;
        end
      end
      if (bus_rd) begin
        bus_rvalid <= 1'b1;
        if (stuck || op_left > 0) begin
          bus_rdata <= op_val;
          if (!stuck) op_left--;
        end else bus_rdata <= '0;
      end
    end
  end

  // SPD byte responder, two-cycle latency
  always @(negedge clk) begin
    spd_ack <= 1'b0;
    if (!rst && !spd_ack) begin
      if (spd_req) begin
        if (sp_cnt == 2) begin
          spd_ack  <= 1'b1;
          spd_data <= spd_byte(spd_addr);
          if (spd_n < 8) spd_log[spd_n] = spd_addr;
          spd_n++;
          sp_cnt = 0;
        end else sp_cnt++;
      end else sp_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int a);
    case (a)
      0, 1, 2, 3: return "R2";
      A_CFG:  return "R5";
      A_MODE: return "R6_R7";
      A_EMR:  return "R11";
      A_OP:   return "R8";
      A_CTRL: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic push(input int a, input logic [31:0] d);
    ea[en] = AW'(a);
    ed[en] = d;
    en++;
  endtask

  task automatic build_exp();
    bit rg;
    int hb, dly;
    logic [31:0] mode;
    longint dens;
    int sum;
    en = 0; esn = 0; exp_err = 0;
    push(1, 0); push(2, 0); push(3, 0);
    push(0, ((req_size - 32'd1) & MASK) | 32'd1);
    es[0] = 3; es[1] = 4; es[2] = 13; es[3] = 17; es[4] = 18;
    es[5] = ddr2 ? 8'd20 : 8'd21;
    esn = 6;
    if (m_wid != 8 && m_wid != 16) begin exp_err = 1; return; end
    rg = ddr2 ? ((m_b20 & 8'h11) != 0) : m_b21[1];
    push(A_CFG, CFGB | (32'(rg) << 17) | (32'(ddr2) << 19) |
                ((m_wid == 16) ? 32'h0020_0000 : 32'h0010_0000));
    hb = -1;
    for (int i = 0; i < 8; i++) if (m_cas[i]) hb = i;
    if (!ddr2) begin
      case (hb)
        1: begin mode = 32'h52; dly = 3; end
        2: begin mode = 32'h22; dly = 3; end
        3: begin mode = 32'h62; dly = 4; end
        4: begin mode = 32'h32; dly = 4; end
        default: begin mode = 32'h42; dly = 5; end
      endcase
    end else begin
      case (hb)
        3: begin mode = 32'h432; dly = 4; end
        4, 5: begin mode = 32'h442; dly = 5; end
        default: begin exp_err = 1; return; end
      endcase
    end
    push(A_OP, 5);
    if (stuck) begin exp_err = 1; return; end
    push(A_MODE, mode); push(A_OP, 3);
    push(A_CTRL, CTRLB | (32'(dly + int'(rg)) << DLSB));
    sum = int'(m_rows) + int'(m_cols);
    dens = (sum < 32) ? (((longint'(1) << sum) * longint'(m_wid) * longint'(m_banks)) >>> 20) : 0;
    if (dens == 'h80) push(A_ACTL, 32'h00);
    else if (dens == 'h100) push(A_ACTL, 32'h10);
    else if (dens == 'h200) push(A_ACTL, 32'h20);
    else begin exp_err = 1; return; end
    if (ddr2) begin push(A_OP, 5); push(A_EMR, EMRV); push(A_OP, 4); end
  endtask

  task automatic run_case();
    int w;
    int nlog;
    string ft;
    build_exp();
    @(negedge clk);
    log_n = 0; spd_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!(done || error) && w < 4000) begin @(negedge clk); w++; end
    if (w >= 4000) begin
      chk(0, "R13", "watchdog, no end flag", 0, 1);
      return;
    end
    nlog = log_n;
    repeat (8) @(negedge clk);
    ft = stuck ? "R12" : "R13";
    chk(done == !exp_err && error == exp_err, ft, "done/error",
        {done, error}, {!exp_err, exp_err});
    chk(log_n == nlog, "R13", "write after end", log_n, nlog);
    chk(log_n == en, ft, "write count", log_n, en);
    for (int i = 0; i < en && i < log_n && i < 32; i++) begin
      chk(log_a[i] == ea[i] && log_d[i] == ed[i], tag_of(int'(ea[i])), "write",
          {log_a[i], log_d[i]}, {ea[i], ed[i]});
      if (int'(ea[i]) == A_CFG)
        chk(log_d[i][17] == ed[i][17], "R4", "registered bit", log_d[i][17], ed[i][17]);
    end
    chk(spd_n == esn, "R3", "spd request count", spd_n, esn);
    for (int i = 0; i < esn && i < spd_n; i++)
      chk(spd_log[i] == es[i], "R3", "spd offset", spd_log[i], es[i]);
  endtask

  task automatic set_default();
    m_rows = 13; m_cols = 10; m_wid = 8; m_banks = 4; m_cas = 8'h1C;
    m_b20 = 0; m_b21 = 0; pend = 1; stuck = 0; req_size = 32'h1000_0000;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL R13 global watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R1: idle after reset
    chk(!done && !error, "R1", "flags after reset", {done, error}, 0);
    chk(log_n == 0 && spd_n == 0 && !spd_req, "R1", "no traffic before start",
        log_n + spd_n, 0);

    // R6: DDR1 CAS sweep with registered toggle (R4)
    for (int p = 0; p < 8; p++)
      for (int r = 0; r < 2; r++) begin
        set_default(); ddr2 = 0;
        m_cas = 8'(1 << p) | ((p > 0) ? 8'(1 << (p - 1)) : 8'h00);
        m_b21 = r ? 8'h02 : 8'h01;
        pend = p % 3;
        run_case();
      end
    // R7: DDR2 CAS sweep, module-type byte variants (R4)
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 4; t++) begin
        set_default(); ddr2 = 1;
        m_cas = 8'(1 << p);
        m_b20 = (t == 0) ? 8'h00 : (t == 1) ? 8'h01 : (t == 2) ? 8'h10 : 8'h04;
        pend = t % 3;
        run_case();
      end
    // R6/R7: empty CAS bitmap
    for (int d = 0; d < 2; d++) begin
      set_default(); ddr2 = d[0]; m_cas = 8'h00; run_case();
    end
    // R5: width byte sweep
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 5; k++) begin
        set_default(); ddr2 = d[0];
        m_wid = (k == 0) ? 8'd0 : (k == 1) ? 8'd4 : (k == 2) ? 8'd8 : (k == 3) ? 8'd16 : 8'd32;
        run_case();
      end
    // R10: density sweep
    for (int rw = 11; rw < 15; rw++)
      for (int cl = 8; cl < 12; cl++)
        for (int k = 0; k < 4; k++) begin
          set_default(); ddr2 = (k == 3);
          m_rows = 8'(rw); m_cols = 8'(cl);
          m_wid = k[0] ? 8'd16 : 8'd8;
          m_banks = k[1] ? 8'd8 : 8'd4;
          m_cas = ddr2 ? 8'h18 : 8'h1C;
          run_case();
        end
    // R10: oversized address space
    set_default(); m_rows = 20; m_cols = 14; run_case();
    // R2: window sizes
    for (int k = 0; k < 3; k++) begin
      set_default();
      req_size = (k == 0) ? 32'h0800_0000 : (k == 1) ? 32'h0001_2345 : 32'h0;
      run_case();
    end
    // R12: operation register never clears
    for (int d = 0; d < 2; d++) begin
      set_default(); ddr2 = d[0]; m_cas = 8'h18; stuck = 1; run_case();
    end
    // R13: normal run directly after an aborted one
    set_default(); ddr2 = 1; m_cas = 8'h38; pend = 2; run_case();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule